// File: doc/BRIEF.md
# Spike Report Packet Assembler

This block gathers neuron firing events produced while a simulation timestep runs and packs them into 512-bit report words for the host link. Every report word starts with a fixed 16-bit marker, then a count of the events it carries. Up to fourteen 32-bit event slots follow, and the word ends with the timestep counter value. Each slot holds a 17-bit neuron index, a 6-bit sub-timestep and a valid flag.

Events arrive on a valid/ready input. A word leaves on a valid/ready output when the fourteenth slot fills, or when an end-of-timestep strobe arrives while at least one slot is occupied. A word is never sent empty. While the output holds an unaccepted word, input ready is low. The output FIFO and the DMA engine sit downstream of this block and are not part of it.

Top module: `spike_report_packer`

## Requirements
- R1: Bits [511:496] of every emitted word equal 16'hEEEE.
- R2: Bits [495:480] give the number of valid slots in the word, zero-extended. The value is always between 1 and 14.
- R3: Event k (k = 0 for the first event accepted into the word) sits in bits [479-32k : 448-32k]. Within a slot, bits [31:24] are 0, bit 23 is 1, bits [22:6] hold the neuron index and bits [5:0] hold the sub-timestep. Slots at or beyond the count are all zeros.
- R4: Bits [31:0] hold the `ts_count` value sampled in the cycle the word's first event was accepted. Later changes of `ts_count` do not affect the word.
- R5: When the fourteenth event of a word is accepted, `out_valid` is high in the next cycle and the following event starts a new word.
- R6: If `ts_end` is high in a cycle where the buffered events, plus any event accepted in that same cycle, number at least one, the word is presented in the next cycle. If `ts_end` arrives with nothing buffered, no word is produced.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` does not change.
- R8: An event accepted in the cycle the previous word is handed over is kept as slot 0 of the next word. With `out_ready` held high, a continuous event stream never sees `in_ready` drop.
- R9: While the output is stalled the event buffer is empty, so a `ts_end` during a stall produces no extra word.
- R10: After reset, `out_valid` is 0, `in_ready` is 1 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Event offered |
| in_ready | output | 1 | Event can be taken this cycle |
| in_neuron | input | 17 | Neuron index of the event |
| in_subts | input | 6 | Sub-timestep of the event |
| ts_count | input | 32 | Current timestep counter |
| ts_end | input | 1 | End-of-timestep strobe |
| out_valid | output | 1 | Report word presented |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 512 | Report word |

## Verification
A wrong fill counter shows at the ports in the word right after the fault: slots are shifted, duplicated or zeroed, or the count field disagrees with the slots. A full word can also come one event early or late, which shows as a missing or extra `out_valid` cycle after the fourteenth event. A stale timestep latch shows in the first word whose counter moved between its first and last event, because the bench changes `ts_count` after every first event. A stall-handling fault shows within the stall window, as either a change of `out_data` or an event taken while `in_ready` should be low.

// File: rtl/spk_pkg.sv
// Package: field widths and marker value of the 512-bit spike report word.
// Assumes: slot layout of pad/valid/neuron/sub-timestep packed MSB to LSB.
package spk_pkg;
    localparam int          TAG_W     = 16;
    localparam int          CNTF_W    = 16;
    localparam int          SLOT_W    = 32;
    localparam logic [15:0] TAG_VALUE = 16'hEEEE;
endpackage

// File: rtl/spk_slot_buf.sv
// Slot buffer: holds the events accepted for the word under construction
// and presents a merged view that includes the event accepted this cycle.
// Assumes: clear and acc may coincide; clear then wins for the fill count.
module spk_slot_buf #(
    parameter int NUM_SLOTS = 14,
    parameter int NRN_W     = 17,
    parameter int SUB_W     = 6,
    parameter int TS_W      = 32,
    parameter int CNT_W     = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            acc,
    input  logic                            clear,
    input  logic [NRN_W-1:0]                in_nrn,
    input  logic [SUB_W-1:0]                in_sub,
    input  logic [TS_W-1:0]                 ts_in,
    output logic [CNT_W-1:0]                cnt,
    output logic [CNT_W-1:0]                m_cnt,
    output logic [NUM_SLOTS-1:0][NRN_W-1:0] m_nrn,
    output logic [NUM_SLOTS-1:0][SUB_W-1:0] m_sub,
    output logic [TS_W-1:0]                 m_ts
);
    logic [TS_W-1:0] ts_q;

    // Fill counter: restart on clear, advance on each accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clear) cnt <= '0;
        else if (acc)   cnt <= cnt + 1'b1;
    end

    // Timestep latch: capture the counter when a word's first event arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ts_q <= '0;
        else if (acc && cnt == '0)  ts_q <= ts_in;
    end

    // Merged view: this cycle's event counts and the counter passes through when empty.
    always_comb begin
        m_cnt = cnt + CNT_W'(acc);
        m_ts  = (cnt == '0) ? ts_in : ts_q;
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [NRN_W-1:0] nrn_q;
        logic [SUB_W-1:0] sub_q;
        logic             hit;

        assign hit = acc && (cnt == CNT_W'(i));

        // Slot storage: write the event into the slot the counter points at.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nrn_q <= '0;
                sub_q <= '0;
            end else if (hit) begin
                nrn_q <= in_nrn;
                sub_q <= in_sub;
            end
        end

        // Slot view: bypass the incoming event into its slot.
        always_comb begin
            m_nrn[i] = hit ? in_nrn : nrn_q;
            m_sub[i] = hit ? in_sub : sub_q;
        end
    end

    // R5
    buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(NUM_SLOTS));
endmodule

// File: rtl/spk_frame_build.sv
// Frame builder: combinational packing of the merged slot view into the
// report word (marker, count, slots with the first event highest, timestep).
// Assumes: m_cnt never exceeds NUM_SLOTS.
module spk_frame_build
    import spk_pkg::*;
#(
    parameter int NUM_SLOTS = 14,
    parameter int NRN_W     = 17,
    parameter int SUB_W     = 6,
    parameter int TS_W      = 32,
    parameter int CNT_W     = 4,
    parameter int WORD_W    = 512
) (
    input  logic [CNT_W-1:0]                m_cnt,
    input  logic [NUM_SLOTS-1:0][NRN_W-1:0] m_nrn,
    input  logic [NUM_SLOTS-1:0][SUB_W-1:0] m_sub,
    input  logic [TS_W-1:0]                 m_ts,
    output logic [WORD_W-1:0]               frame
);
    localparam int PAD_W  = SLOT_W - 1 - NRN_W - SUB_W;
    localparam int CNT_LO = WORD_W - TAG_W - CNTF_W;

    // Header and trailer fields.
    assign frame[WORD_W-1 -: TAG_W]  = TAG_VALUE;
    assign frame[CNT_LO +: CNTF_W]   = CNTF_W'(m_cnt);
    assign frame[TS_W-1:0]           = m_ts;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pack
        localparam int LSB = TS_W + (NUM_SLOTS - 1 - i) * SLOT_W;
        // Slot word: flagged event when occupied, zeros otherwise.
        assign frame[LSB +: SLOT_W] = (CNT_W'(i) < m_cnt)
            ? {{PAD_W{1'b0}}, 1'b1, m_nrn[i], m_sub[i]}
            : '0;
    end
endmodule

// File: rtl/spk_emit_ctrl.sv
// Emit control: decides when a word leaves and holds it in the output
// register until the consumer takes it; frees input ready accordingly.
// Assumes: frame reflects the merged view of the current cycle.
module spk_emit_ctrl
    import spk_pkg::*;
#(
    parameter int NUM_SLOTS = 14,
    parameter int CNT_W     = 4,
    parameter int WORD_W    = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  m_cnt,
    input  logic              ts_end,
    input  logic [WORD_W-1:0] frame,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              out_free,
    output logic              emit
);
    localparam int CNT_LO = WORD_W - TAG_W - CNTF_W;

    // Emit decision: full word, or strobe with something to send, and room.
    always_comb begin
        out_free = !out_valid || out_ready;
        emit     = out_free && ((m_cnt == CNT_W'(NUM_SLOTS)) ||
                                (ts_end && m_cnt != '0));
    end

    // Output valid: set on emit, drop when taken without a replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid <= 1'b0;
        else if (emit)      out_valid <= 1'b1;
        else if (out_ready) out_valid <= 1'b0;
    end

    // Output word register: load only on emit.
    always_ff @(posedge clk) begin
        if (!rst_n)    out_data <= '0;
        else if (emit) out_data <= frame;
    end

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R2
    nonzero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[CNT_LO +: CNTF_W] != '0) &&
                      (out_data[CNT_LO +: CNTF_W] <= CNTF_W'(NUM_SLOTS)));
    // R1
    tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_data[WORD_W-1 -: TAG_W] == TAG_VALUE);
endmodule

// File: rtl/spike_report_packer.sv
// Top: spike report packet assembler. Accepts events, buffers up to
// NUM_SLOTS-1 of them, and emits a report word when full or at timestep end.
// Assumes: ts_end is a one-cycle strobe; ts_count is stable per timestep.
module spike_report_packer
    import spk_pkg::*;
#(
    parameter int  NUM_SLOTS = 14,
    parameter int  NRN_W     = 17,
    parameter int  SUB_W     = 6,
    parameter int  TS_W      = 32,
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1),
    localparam int WORD_W    = TAG_W + CNTF_W + NUM_SLOTS * SLOT_W + TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NRN_W-1:0]  in_neuron,
    input  logic [SUB_W-1:0]  in_subts,
    input  logic [TS_W-1:0]   ts_count,
    input  logic              ts_end,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    logic                            acc;
    logic                            emit;
    logic                            out_free;
    logic [CNT_W-1:0]                cnt;
    logic [CNT_W-1:0]                m_cnt;
    logic [NUM_SLOTS-1:0][NRN_W-1:0] m_nrn;
    logic [NUM_SLOTS-1:0][SUB_W-1:0] m_sub;
    logic [TS_W-1:0]                 m_ts;
    logic [WORD_W-1:0]               frame;

    // Input handshake: take events only when the output register has room.
    always_comb begin
        in_ready = out_free;
        acc      = in_valid && in_ready;
    end

    spk_slot_buf #(
        .NUM_SLOTS(NUM_SLOTS), .NRN_W(NRN_W), .SUB_W(SUB_W),
        .TS_W(TS_W), .CNT_W(CNT_W)
    ) i_buf (
        .clk(clk), .rst_n(rst_n), .acc(acc), .clear(emit),
        .in_nrn(in_neuron), .in_sub(in_subts), .ts_in(ts_count),
        .cnt(cnt), .m_cnt(m_cnt), .m_nrn(m_nrn), .m_sub(m_sub), .m_ts(m_ts)
    );

    spk_frame_build #(
        .NUM_SLOTS(NUM_SLOTS), .NRN_W(NRN_W), .SUB_W(SUB_W),
        .TS_W(TS_W), .CNT_W(CNT_W), .WORD_W(WORD_W)
    ) i_build (
        .m_cnt(m_cnt), .m_nrn(m_nrn), .m_sub(m_sub), .m_ts(m_ts), .frame(frame)
    );

    spk_emit_ctrl #(
        .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .WORD_W(WORD_W)
    ) i_emit (
        .clk(clk), .rst_n(rst_n), .m_cnt(m_cnt), .ts_end(ts_end),
        .frame(frame), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_free(out_free), .emit(emit)
    );

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);
    // R9
    stall_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> cnt == '0);
    // R5
    full_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && cnt == CNT_W'(NUM_SLOTS - 1) |=> out_valid);
endmodule

// File: tb/test_spike_report_packer.sv
`timescale 1ns/100ps
module test_spike_report_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [16:0]  in_neuron = '0;
    logic [5:0]   in_subts = '0;
    logic [31:0]  ts_count = '0;
    logic         ts_end = 1'b0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [511:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    int stall_waits = 0;
    int cap_n = 0;
    logic [511:0] cap_q [0:63];

    always #2.5 clk = ~clk;

    spike_report_packer i_spike_report_packer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_neuron(in_neuron), .in_subts(in_subts), .ts_count(ts_count),
        .ts_end(ts_end), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    // Vector table: events per word, first neuron, first sub-timestep, timestep.
    localparam int N_VEC = 6;
    localparam int          V_N   [N_VEC] = '{1, 5, 14, 13, 3, 14};
    localparam int          V_NRN [N_VEC] = '{42, 1000, 5123, 131032, 0, 100};
    localparam int          V_SUB [N_VEC] = '{0, 7, 60, 63, 1, 0};
    localparam logic [31:0] V_TS  [N_VEC] = '{32'd1500, 32'd7, 32'hFFFF_FFF0,
                                              32'd0, 32'h8000_0000, 32'd2};

    // Monitor: record a word whose handshake completes at the next edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid && out_ready && cap_n < 64) begin
            cap_q[cap_n] = out_data;
            cap_n++;
        end
    end

    function automatic logic [511:0] exp_word(int n, int base, int sub0, logic [31:0] ts);
        logic [511:0] w;
        logic [16:0]  nrn;
        logic [5:0]   sb;
        w = '0;
        w[511:496] = 16'hEEEE;
        w[495:480] = 16'(n);
        for (int k = 0; k < n; k++) begin
            nrn = 17'(base + 3 * k);
            sb  = 6'(sub0 + k);
            w[479 - 32*k -: 32] = {8'h00, 1'b1, nrn, sb};
        end
        w[31:0] = ts;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [511:0] act,
                       input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [16:0] nrn, input logic [5:0] sb,
                        input logic [31:0] ts, input bit strb);
        @(negedge clk);
        in_valid = 1'b1; in_neuron = nrn; in_subts = sb; ts_count = ts; ts_end = strb;
        #1;
        while (!in_ready) begin
            stall_waits++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; ts_end = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk); ts_end = 1'b1; in_valid = 1'b0;
        @(negedge clk); ts_end = 1'b0;
    endtask

    task automatic send_word(int n, int base, int sub0, logic [31:0] ts);
        for (int k = 0; k < n; k++)
            send(17'(base + 3*k), 6'(sub0 + k), (k == 0) ? ts : ts + 32'd100 + 32'(k), 1'b0);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base_n;
        logic [511:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(out_valid == 1'b0, "R10 out_valid", 512'(out_valid), 512'd0);
        chk(in_ready == 1'b1, "R10 in_ready", 512'(in_ready), 512'd1);

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int v = 0; v < N_VEC; v++) begin
            base_n = cap_n;
            send_word(V_N[v], V_NRN[v], V_SUB[v], V_TS[v]);
            if (V_N[v] < 14) strobe();
            repeat (3) @(negedge clk);
            chk(cap_n == base_n + 1, "R5/R6 word count", 512'(cap_n), 512'(base_n + 1));
            chk(cap_q[base_n] == exp_word(V_N[v], V_NRN[v], V_SUB[v], V_TS[v]),
                "R1 R2 R3 R4 word content", cap_q[base_n],
                exp_word(V_N[v], V_NRN[v], V_SUB[v], V_TS[v]));
        end

        // R6: strobe with empty buffer yields nothing
        base_n = cap_n;
        strobe();
        repeat (3) @(negedge clk);
        chk(cap_n == base_n, "R6 empty strobe", 512'(cap_n), 512'(base_n));

        // R6: event accepted in the strobe cycle joins the word
        base_n = cap_n;
        send(17'd9, 6'd4, 32'd77, 1'b0);
        send(17'd12, 6'd5, 32'd78, 1'b1);
        idle();
        repeat (3) @(negedge clk);
        chk(cap_n == base_n + 1 && cap_q[base_n] == exp_word(2, 9, 4, 32'd77),
            "R6 same-cycle strobe", cap_q[base_n], exp_word(2, 9, 4, 32'd77));

        // R7 R9 R8: stall with a full word held
        base_n = cap_n;
        @(negedge clk); out_ready = 1'b0;
        send_word(14, 300, 10, 32'd55);
        @(negedge clk);
        held = out_data;
        chk(out_valid == 1'b1, "R7 word presented", 512'(out_valid), 512'd1);
        in_valid = 1'b1; in_neuron = 17'd777; in_subts = 6'd33; ts_count = 32'd900; ts_end = 1'b1;
        for (int c = 0; c < 4; c++) begin
            #1;
            chk(in_ready == 1'b0, "R7 in_ready low", 512'(in_ready), 512'd0);
            @(negedge clk);
        end
        #1;
        chk(out_data == held, "R7 out_data stable", out_data, held);
        ts_end = 1'b0;
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        idle();
        repeat (2) @(negedge clk);
        chk(cap_n == base_n + 1, "R9 no extra word", 512'(cap_n), 512'(base_n + 1));
        chk(cap_q[base_n] == exp_word(14, 300, 10, 32'd55), "R7 held word",
            cap_q[base_n], exp_word(14, 300, 10, 32'd55));
        strobe();
        repeat (3) @(negedge clk);
        chk(cap_n == base_n + 2 && cap_q[base_n+1] == exp_word(1, 777, 33, 32'd900),
            "R8 event kept across handover", cap_q[base_n+1], exp_word(1, 777, 33, 32'd900));

        // R8: continuous stream of 28 events, ready held high
        base_n = cap_n;
        stall_waits = 0;
        for (int k = 0; k < 28; k++)
            send(17'(2000 + 3*k), 6'(k), (k == 0) ? 32'd10 : (k == 14) ? 32'd11 : 32'd500, 1'b0);
        idle();
        repeat (3) @(negedge clk);
        chk(stall_waits == 0, "R8 no input stall", 512'(stall_waits), 512'd0);
        chk(cap_n == base_n + 2, "R8 two words", 512'(cap_n), 512'(base_n + 2));
        chk(cap_q[base_n] == exp_word(14, 2000, 0, 32'd10), "R8 first word",
            cap_q[base_n], exp_word(14, 2000, 0, 32'd10));
        chk(cap_q[base_n+1] == exp_word(14, 2042, 14, 32'd11), "R8 second word",
            cap_q[base_n+1], exp_word(14, 2042, 14, 32'd11));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule